// File: doc/BRIEF.md
# Character and Bitmap Pixel Generator

This block converts a stream of bytes fetched from video memory into a stream of pixels. It has two kinds of work. In character mode, every cell arrives as two bytes. The first is a code point and the second is a colour byte. The code point and the current scan row index a computed glyph table. Each glyph bit then chooses between the foreground colour and the background colour through a 2:1 multiplexer. In bitmap mode, every byte is one fetch slot. It is shown either as a single wide colour or as two narrow colour nibbles.

Bytes enter on a valid/ready stream. The block takes a byte only in a cycle where `in_valid` and `in_ready` are both high. It holds one slot in its output shifter and one completed slot in reserve. While the reserve is occupied, `in_ready` stays low and the producer must keep its byte steady. A pixel-rate enable advances the output by one pixel. All output colour bits come from a single register, so they change on the same clock edge. A blanking input darkens the output. It also discards any partly assembled cell, so that the next active line starts cleanly on a code-point byte.

Top module: `attr_pixel_gen`

## Requirements
- R1: After reset `out_rgb` is 0 and `out_valid` is 0. `in_ready` is 1 whenever `blank` is low and no completed slot is waiting.
- R2: Character mode (`mode[0]`=0) takes a code byte and then a colour byte. The cell yields 8 pixels, glyph MSB first. A glyph bit of 1 shows the foreground, which is the colour byte's bits [3:0]. A glyph bit of 0 shows the background, which is bits [7:4]. A 4-bit colour c appears on `out_rgb` as {c,c}.
- R3: The glyph row equals code XOR (r*8'h11). Here r is `scan_row[3:0]` when `mode[1]`=1 (16-row glyphs), and `{1'b0,scan_row[2:0]}` when `mode[1]`=0 (8-row glyphs). The scan row is sampled with the colour byte.
- R4: Low-resolution bitmap mode (`mode`=2'b01) shows each byte unchanged on `out_rgb` for 4 pixels.
- R5: High-resolution bitmap mode (`mode`=2'b11) shows bits [7:4] of each byte as 2 pixels, then bits [3:0] as 2 pixels, each expanded to {c,c}.
- R6: Each `pix_en` cycle produces exactly one output update on the next edge. `out_valid` is high for that one cycle when a real pixel was produced. `out_rgb` holds its value in cycles without `pix_en`.
- R7: While a completed slot waits behind a busy shifter, `in_ready` is low and no byte is taken. Pixels still come out in the order the bytes were accepted, with none lost or repeated.
- R8: While `blank` is high, `in_ready` is low. After the following edge, `out_rgb` is 0 and `out_valid` is 0. All queued pixels and any half-received cell are discarded.
- R9: A `pix_en` cycle with no pixel available gives `out_rgb`=0 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| mode | input | 2 | bit0: character(0)/bitmap(1); bit1: low(0)/high(1) resolution |
| scan_row | input | 4 | glyph row being drawn |
| blank | input | 1 | blanking interval: darken and flush |
| pix_en | input | 1 | pixel-rate enable |
| in_valid | input | 1 | byte offered |
| in_ready | output | 1 | byte will be taken this cycle |
| in_data | input | 8 | fetched byte |
| out_rgb | output | 8 | registered pixel colour |
| out_valid | output | 1 | a pixel was produced on the last edge |

## Verification
A slot becomes visible one edge after its last byte is accepted. Its first pixel reaches `out_rgb` on the edge that follows the first `pix_en` after that. The reserve-slot handover keeps later pixels back to back, one per enabled cycle. The blanking flush and the underrun darkening both appear on the edge that samples them. The bench drives inputs on the falling edge and reads `in_ready` just before the rising edge to learn which bytes were taken. Its reference model steps once per rising edge: it emits from pixels queued at earlier edges, then appends pixels from bytes accepted at this edge. The outputs are compared 1 ns after every rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pxg_pkg.sv
package pxg_pkg;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = BYTE_W / 2;
  localparam int ROW_W   = 4;
  localparam int CNT_W   = 4;
  localparam int CELL_PX = 8;
  localparam int SLOT_PX = 4;

  typedef struct packed {
    logic [BYTE_W-1:0] bits;
    logic [CNT_W-1:0]  npix;
    logic [BYTE_W-1:0] col_a;
    logic [BYTE_W-1:0] col_b;
  } slot_t;

  function automatic logic [BYTE_W-1:0] nib_expand(input logic [NIB_W-1:0] c);
    return {c, c};
  endfunction

  // computed glyph store: row pattern from code point and scan row
  function automatic logic [BYTE_W-1:0] font_row(input logic [BYTE_W-1:0] code,
                                                  input logic [ROW_W-1:0] row,
                                                  input logic tall);
    logic [ROW_W-1:0] r;
    r = tall ? row : {1'b0, row[ROW_W-2:0]};
    return code ^ (BYTE_W'(r) * 8'h11);
  endfunction
endpackage

// File: rtl/pxg_slot_build.sv
module pxg_slot_build
  import pxg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank,
  input  logic [1:0]        mode,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              take,
  output logic              pend_full,
  output slot_t             pend_slot
);
  logic              code_held;
  logic [BYTE_W-1:0] code_q;
  logic              accept, complete;
  slot_t             nxt;

  assign in_ready = !pend_full && !blank;
  assign accept   = in_valid && in_ready;
  assign complete = accept && (mode[0] || code_held);

  always_comb begin
    if (mode[0]) begin
      nxt.npix = CNT_W'(SLOT_PX);
      if (mode[1]) begin
        nxt.bits  = 8'hC0;
        nxt.col_a = nib_expand(in_data[BYTE_W-1:NIB_W]);
        nxt.col_b = nib_expand(in_data[NIB_W-1:0]);
      end else begin
        nxt.bits  = 8'hF0;
        nxt.col_a = in_data;
        nxt.col_b = in_data;
      end
    end else begin
      nxt.npix  = CNT_W'(CELL_PX);
      nxt.bits  = font_row(code_q, scan_row, mode[1]);
      nxt.col_a = nib_expand(in_data[NIB_W-1:0]);
      nxt.col_b = nib_expand(in_data[BYTE_W-1:NIB_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || blank) begin
      pend_full <= 1'b0;
      code_held <= 1'b0;
      code_q    <= '0;
      pend_slot <= '0;
    end else begin
      if (complete) begin
        pend_full <= 1'b1;
        pend_slot <= nxt;
      end else if (take) begin
        pend_full <= 1'b0;
      end
      if (accept) begin
        if (mode[0]) begin
          code_held <= 1'b0;
        end else begin
          code_held <= !code_held;
          if (!code_held) code_q <= in_data;
        end
      end
    end
  end

  // R7: a waiting slot is neither lost nor overwritten
  a_r7_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_full && !take && !blank) |=> (pend_full && $stable(pend_slot)));
endmodule

// File: rtl/pxg_pixel_out.sv
module pxg_pixel_out
  import pxg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank,
  input  logic              pix_en,
  input  logic              pend_full,
  input  slot_t             pend_slot,
  output logic              take,
  output logic [BYTE_W-1:0] out_rgb,
  output logic              out_valid
);
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh_bits, sh_a, sh_b;
  logic              have, emit, cur_bit;
  logic [BYTE_W-1:0] cur_a, cur_b, pix;

  assign have    = (cnt != '0);
  assign take    = pend_full && !blank &&
                   (!have || (pix_en && cnt == CNT_W'(1)));
  assign emit    = pix_en && !blank && (have || pend_full);
  assign cur_bit = have ? sh_bits[BYTE_W-1] : pend_slot.bits[BYTE_W-1];
  assign cur_a   = have ? sh_a : pend_slot.col_a;
  assign cur_b   = have ? sh_b : pend_slot.col_b;
  // 2:1 foreground/background selection
  assign pix     = cur_bit ? cur_a : cur_b;

  always_ff @(posedge clk) begin
    if (!rst_n || blank) begin
      cnt       <= '0;
      sh_bits   <= '0;
      sh_a      <= '0;
      sh_b      <= '0;
      out_rgb   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      if (pix_en) out_rgb <= emit ? pix : '0;
      if (have && pix_en) begin
        if (take) begin
          sh_bits <= pend_slot.bits;
          cnt     <= pend_slot.npix;
          sh_a    <= pend_slot.col_a;
          sh_b    <= pend_slot.col_b;
        end else begin
          sh_bits <= sh_bits << 1;
          cnt     <= cnt - CNT_W'(1);
        end
      end else if (!have && take) begin
        sh_a <= pend_slot.col_a;
        sh_b <= pend_slot.col_b;
        if (pix_en) begin
          sh_bits <= pend_slot.bits << 1;
          cnt     <= pend_slot.npix - CNT_W'(1);
        end else begin
          sh_bits <= pend_slot.bits;
          cnt     <= pend_slot.npix;
        end
      end
    end
  end

  // R6: output register only moves on an enabled cycle
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !blank) |=> $stable(out_rgb));
  // R6: a pixel is flagged only after an enable
  a_r6_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> !out_valid);
  // R8: blanking darkens the output on the next edge
  a_r8_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (out_rgb == '0 && !out_valid));
  // R9: an enable with nothing queued darkens the output
  a_r9_underrun_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !blank && !have && !pend_full) |=> (out_rgb == '0 && !out_valid));
endmodule

// File: rtl/attr_pixel_gen.sv
module attr_pixel_gen
  import pxg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic              blank,
  input  logic              pix_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic [BYTE_W-1:0] out_rgb,
  output logic              out_valid
);
  logic  pend_full, take;
  slot_t pend_slot;

  pxg_slot_build u_build (
    .clk(clk), .rst_n(rst_n), .blank(blank), .mode(mode), .scan_row(scan_row),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .take(take), .pend_full(pend_full), .pend_slot(pend_slot)
  );

  pxg_pixel_out u_out (
    .clk(clk), .rst_n(rst_n), .blank(blank), .pix_en(pix_en),
    .pend_full(pend_full), .pend_slot(pend_slot), .take(take),
    .out_rgb(out_rgb), .out_valid(out_valid)
  );

  // R8: no byte is taken during blanking
  a_r8_no_take_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !in_ready);
endmodule

// File: tb/attr_pixel_gen_bench.sv
module attr_pixel_gen_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic [3:0] scan_row = 0;
  logic blank = 0, pix_en = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid;
  logic [7:0] out_rgb;

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  int pq[$];
  bit have_code = 0;
  logic [7:0] code_b = 0, exp_rgb = 0;
  bit exp_valid = 0;
  int ptr = 0;

  always #2 clk = ~clk;

  attr_pixel_gen u_attr_pixel_gen (.*);

  task automatic chk(input string req, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] gen_byte(input int k);
    return 8'((k * 37 + 11) ^ (k >> 3));
  endfunction

  task automatic model_push(input logic [7:0] d);
    if (mode[0]) begin
      if (mode[1]) begin
        repeat (2) pq.push_back({d[7:4], d[7:4]});
        repeat (2) pq.push_back({d[3:0], d[3:0]});
      end else repeat (4) pq.push_back(d);
    end else if (!have_code) begin
      code_b = d; have_code = 1;
    end else begin
      logic [3:0] r;
      logic [7:0] g;
      r = mode[1] ? scan_row : {1'b0, scan_row[2:0]};
      g = code_b ^ {r, r};
      for (int i = 7; i >= 0; i--)
        pq.push_back(g[i] ? {d[3:0], d[3:0]} : {d[7:4], d[7:4]});
      have_code = 0;
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare after it
  task automatic tick(input bit v, input bit pe);
    bit rdy;
    @(negedge clk);
    in_valid = v; pix_en = pe; in_data = gen_byte(ptr);
    #1 rdy = in_ready;
    @(posedge clk);
    if (blank) begin
      pq.delete(); have_code = 0; exp_rgb = 0; exp_valid = 0;
    end else begin
      exp_valid = 0;
      if (pe) begin
        if (pq.size() > 0) begin exp_rgb = 8'(pq.pop_front()); exp_valid = 1; end
        else exp_rgb = 0;
      end
      if (v && rdy) begin model_push(in_data); ptr++; end
    end
    #1;
    chk({cur_req, " rgb"}, out_rgb, exp_rgb);
    chk({cur_req, " valid"}, out_valid, exp_valid);
  endtask

  task automatic run(input int n, input int vev, input int pev);
    for (int c = 0; c < n; c++) tick((c % vev) == 0, (c % pev) == 0);
  endtask

  task automatic do_blank(input int n);
    blank = 1;
    for (int c = 0; c < n; c++) tick(1, 1);
    blank = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rgb", out_rgb, 0);
    chk("R1 valid", out_valid, 0);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 ready", in_ready, 1);

    cur_req = "R2 R3 short glyph"; mode = 2'b00; scan_row = 4'd13;
    run(120, 1, 1);
    do_blank(3);
    cur_req = "R3 tall glyph"; mode = 2'b10; scan_row = 4'd13;
    run(120, 1, 1);
    scan_row = 4'd6; run(60, 1, 1);
    do_blank(3);
    cur_req = "R4 lowres bitmap"; mode = 2'b01;
    run(100, 1, 1);
    do_blank(3);
    cur_req = "R5 highres bitmap"; mode = 2'b11;
    run(100, 1, 1);
    do_blank(3);
    cur_req = "R6 sparse enable"; mode = 2'b00; scan_row = 4'd2;
    run(150, 1, 3);
    do_blank(3);
    cur_req = "R9 underrun"; mode = 2'b01;
    run(120, 7, 1);
    do_blank(3);

    cur_req = "R7 backpressure"; mode = 2'b11;
    run(8, 1, 1000);
    @(negedge clk); #1;
    chk("R7 ready low while slot waits", in_ready, 0);
    run(80, 1, 1);
    cur_req = "R8 blank flush";
    mode = 2'b00; scan_row = 4'd1;
    tick(1, 0);
    blank = 1;
    @(negedge clk); #1;
    chk("R8 ready low in blank", in_ready, 0);
    tick(1, 1); tick(1, 1);
    blank = 0;
    run(60, 1, 1);
    run(20, 1000, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule